// File: doc/BRIEF.md
# Eight-Operand Signed Compressor Tree

This block adds eight signed 8-bit two's complement operands in a single combinational pass and drives an 11-bit signed total. The operands are split into two groups of four. Each group is sign-extended to 10 bits and fed to a row of [4:2] carry-save cells, which leaves a 10-bit sum vector and a 10-bit carry vector per group. A second row of [4:2] cells, 11 bits wide, folds those four vectors into two. A ripple-carry adder then resolves the last pair into the total.

Each [4:2] cell takes four operand bits and a lateral carry from the bit below. It passes on a lateral carry equal to the majority of its first three inputs. Its output carry is the incoming lateral carry when the four operand bits have odd parity, and the fourth operand bit when the parity is even. Its sum bit is the parity of all five inputs. The lateral carry into bit 0 is zero, so a lateral carry never travels more than one bit. The carry vector sits one bit above the sum vector. Bits pushed past the top of a row are dropped, so every row works modulo 2 to the power of its width. The block has no clock and no state.

Top module: `oct_csa_tree`

## Requirements
- R1: For any eight operands, `total` read as 11-bit two's complement equals the exact signed sum of the operands, each operand read as 8-bit two's complement.
- R2: When all eight operands are -128 (0x80), `total` is -1024 (0x400), the most negative value.
- R3: When all eight operands are +127 (0x7F), `total` is +1016 (0x3F8), the most positive value.
- R4: The operands 73, -52, 22, -127, -31, 17, 47 and -80 give a `total` of -131.
- R5: Each first-level group of four operands (op0..op3 and op4..op7) is resolved exactly inside 10 bits, including the group extremes -512 and +508. With one group at -512 and the other at +508, in either placement, `total` is -4.
- R6: With every operand zero, `total` is zero.
- R7: `total` does not depend on the order of the operands. Rotating the eight operands across the input ports leaves it unchanged.
- R8: A negative operand is sign-extended to the full width. A single -1 with all other operands zero gives `total` = 0x7FF, and eight operands of -1 give -8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op0 | input | 8 | Operand 0, two's complement, first group |
| op1 | input | 8 | Operand 1, two's complement, first group |
| op2 | input | 8 | Operand 2, two's complement, first group |
| op3 | input | 8 | Operand 3, two's complement, first group |
| op4 | input | 8 | Operand 4, two's complement, second group |
| op5 | input | 8 | Operand 5, two's complement, second group |
| op6 | input | 8 | Operand 6, two's complement, second group |
| op7 | input | 8 | Operand 7, two's complement, second group |
| total | output | 11 | Signed sum of the eight operands |

## Verification
Two effects can land in the same evaluation. The first is a carry dropped off the top of a first-level 10-bit row. The second is the sign-extension of that row's vectors into the 11-bit second level. If either is handled wrongly, the error shows up only as a 1024 offset in `total`. The cases that provoke both together put every operand of a group at its negative or positive limit. They also use the worked example and a few hundred random sets, where mixed signs flip the top bits of the vectors. Each case is judged by comparing `total` with a signed sum computed in the bench. Rotated copies of the same operands must give the same value.

// File: rtl/oct_csa_pkg.sv
package oct_csa_pkg;
  // operand width; the tree shape below is fixed at eight operands
  parameter int OPW = 8;
  localparam int NOPS = 8;
  localparam int GRP  = 4;                 // operands per first-level row
  localparam int L1W  = OPW + 2;           // four operands need two guard bits
  localparam int L2W  = OPW + 3;           // eight operands need three
endpackage

// File: rtl/csa42_cell.sv
module csa42_cell (
  input  logic x,
  input  logic y,
  input  logic w,
  input  logic z,
  input  logic tIn,
  output logic tOut,
  output logic cOut,
  output logic s
);
  logic par4;

  always_comb begin
    par4 = x ^ y ^ w ^ z;
    tOut = (x & y) | (x & w) | (y & w);
    cOut = par4 ? tIn : z;
    s    = par4 ^ tIn;
  end
endmodule

// File: rtl/csa42_row.sv
module csa42_row #(
  parameter int W = 10
) (
  input  logic [W-1:0] inX,
  input  logic [W-1:0] inY,
  input  logic [W-1:0] inW,
  input  logic [W-1:0] inZ,
  output logic [W-1:0] sumVec,
  output logic [W-1:0] carryVec
);
  logic [W:0]   lat;
  logic [W-1:0] co;
  logic         unusedTopCarries;

  assign lat[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    csa42_cell u_cell (
      .x   (inX[i]),
      .y   (inY[i]),
      .w   (inW[i]),
      .z   (inZ[i]),
      .tIn (lat[i]),
      .tOut(lat[i+1]),
      .cOut(co[i]),
      .s   (sumVec[i])
    );
  end

  // the carry vector is weighted one bit up; what leaves the top is dropped
  assign carryVec         = {co[W-2:0], 1'b0};
  assign unusedTopCarries = lat[W] ^ co[W-1];
endmodule

// File: rtl/cpa_ripple.sv
module cpa_ripple #(
  parameter int W = 11
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0] cy;
  logic       unusedCarryOut;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = a[i] ^ b[i] ^ cy[i];
    assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
  end

  assign unusedCarryOut = cy[W];
endmodule

// File: rtl/oct_csa_tree.sv
module oct_csa_tree
  import oct_csa_pkg::*;
(
  input  logic [OPW-1:0] op0,
  input  logic [OPW-1:0] op1,
  input  logic [OPW-1:0] op2,
  input  logic [OPW-1:0] op3,
  input  logic [OPW-1:0] op4,
  input  logic [OPW-1:0] op5,
  input  logic [OPW-1:0] op6,
  input  logic [OPW-1:0] op7,
  output logic [L2W-1:0] total
);
  localparam int EXT1 = L1W - OPW;
  localparam int EXT2 = L2W - L1W;

  logic [OPW-1:0] opv [NOPS];
  logic [L1W-1:0] ext1 [NOPS];
  logic [L1W-1:0] l1SumA, l1CarryA, l1SumB, l1CarryB;
  logic [L2W-1:0] l2InA, l2InB, l2InC, l2InD;
  logic [L2W-1:0] l2Sum, l2Carry;

  assign opv[0] = op0;
  assign opv[1] = op1;
  assign opv[2] = op2;
  assign opv[3] = op3;
  assign opv[4] = op4;
  assign opv[5] = op5;
  assign opv[6] = op6;
  assign opv[7] = op7;

  for (genvar k = 0; k < NOPS; k++) begin : g_ext
    assign ext1[k] = {{EXT1{opv[k][OPW-1]}}, opv[k]};
  end

  csa42_row #(.W(L1W)) u_rowA (
    .inX(ext1[0]), .inY(ext1[1]), .inW(ext1[2]), .inZ(ext1[3]),
    .sumVec(l1SumA), .carryVec(l1CarryA)
  );

  csa42_row #(.W(L1W)) u_rowB (
    .inX(ext1[GRP+0]), .inY(ext1[GRP+1]), .inW(ext1[GRP+2]), .inZ(ext1[GRP+3]),
    .sumVec(l1SumB), .carryVec(l1CarryB)
  );

  // two guard bits in the first level make plain sign-extension of each vector exact
  assign l2InA = {{EXT2{l1SumA[L1W-1]}},   l1SumA};
  assign l2InB = {{EXT2{l1CarryA[L1W-1]}}, l1CarryA};
  assign l2InC = {{EXT2{l1SumB[L1W-1]}},   l1SumB};
  assign l2InD = {{EXT2{l1CarryB[L1W-1]}}, l1CarryB};

  csa42_row #(.W(L2W)) u_rowTop (
    .inX(l2InA), .inY(l2InB), .inW(l2InC), .inZ(l2InD),
    .sumVec(l2Sum), .carryVec(l2Carry)
  );

  cpa_ripple #(.W(L2W)) u_cpa (
    .a  (l2Sum),
    .b  (l2Carry),
    .sum(total)
  );
endmodule

// File: rtl/oct_csa_tree_chk.sv
module oct_csa_tree_chk
  import oct_csa_pkg::*;
(
  input logic [OPW-1:0] op0,
  input logic [OPW-1:0] op1,
  input logic [OPW-1:0] op2,
  input logic [OPW-1:0] op3,
  input logic [OPW-1:0] op4,
  input logic [OPW-1:0] op5,
  input logic [OPW-1:0] op6,
  input logic [OPW-1:0] op7,
  input logic [L1W-1:0] l1SumA,
  input logic [L1W-1:0] l1CarryA,
  input logic [L1W-1:0] l1SumB,
  input logic [L1W-1:0] l1CarryB,
  input logic [L2W-1:0] l2Sum,
  input logic [L2W-1:0] l2Carry,
  input logic [L2W-1:0] total
);
  int grpA, grpB, exact, got;
  logic [L1W-1:0] pairA, pairB;
  logic [L2W-1:0] pairTop;

  always_comb begin
    grpA = int'($signed(op0)) + int'($signed(op1)) + int'($signed(op2)) + int'($signed(op3));
    grpB = int'($signed(op4)) + int'($signed(op5)) + int'($signed(op6)) + int'($signed(op7));
    exact   = grpA + grpB;
    got     = int'($signed(total));
    pairA   = l1SumA + l1CarryA;
    pairB   = l1SumB + l1CarryB;
    pairTop = l2Sum + l2Carry;
    if (!$isunknown({op0, op1, op2, op3, op4, op5, op6, op7})) begin
      p_sum_exact_r1: assert (got == exact)
        else $error("total %0d differs from exact sum %0d", got, exact);
      p_level2_exact_r1: assert (pairTop == exact[L2W-1:0])
        else $error("second-level vectors do not resolve to the sum");
      p_range_r3: assert (got >= -1024 && got <= 1016)
        else $error("total %0d outside reachable range", got);
      p_level1_exact_r5: assert (pairA == grpA[L1W-1:0] && pairB == grpB[L1W-1:0])
        else $error("first-level vectors do not resolve to their group sums");
      p_level1_signext_r5: assert (l1SumA[L1W-1] == l1SumA[L1W-2] && l1SumB[L1W-1] == l1SumB[L1W-2])
        else $error("first-level sum vector top bits disagree");
    end
  end
endmodule

bind oct_csa_tree oct_csa_tree_chk u_chk (
  .op0(op0), .op1(op1), .op2(op2), .op3(op3),
  .op4(op4), .op5(op5), .op6(op6), .op7(op7),
  .l1SumA(l1SumA), .l1CarryA(l1CarryA),
  .l1SumB(l1SumB), .l1CarryB(l1CarryB),
  .l2Sum(l2Sum), .l2Carry(l2Carry),
  .total(total)
);

// File: tb/tb_oct_csa_tree.sv
module tb_oct_csa_tree;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic       rst;
  logic [7:0] op [8];
  logic [10:0] total;

  int  nRun  = 0;
  int  nFail = 0;
  bit  done  = 1'b0;

  oct_csa_tree dut (
    .op0(op[0]), .op1(op[1]), .op2(op[2]), .op3(op[3]),
    .op4(op[4]), .op5(op[5]), .op6(op[6]), .op7(op[7]),
    .total(total)
  );

  // eight operands followed by the expected total
  localparam int TV [9][9] = '{
    '{  73,  -52,   22, -127,  -31,   17,   47,  -80,  -131},
    '{-128, -128, -128, -128, -128, -128, -128, -128, -1024},
    '{ 127,  127,  127,  127,  127,  127,  127,  127,  1016},
    '{   0,    0,    0,    0,    0,    0,    0,    0,     0},
    '{  -1,    0,    0,    0,    0,    0,    0,    0,    -1},
    '{-128, -128, -128, -128,  127,  127,  127,  127,    -4},
    '{ 127,  127,  127,  127, -128, -128, -128, -128,    -4},
    '{   1,    2,    3,    4,    5,    6,    7,    8,    36},
    '{  -1,   -1,   -1,   -1,   -1,   -1,   -1,   -1,    -8}
  };
  string tag [9] = '{"R4", "R2", "R3", "R6", "R8", "R5", "R5", "R1", "R8"};

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: total got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input int v [8]);
    @(posedge clk);
    for (int j = 0; j < 8; j++) op[j] = v[j][7:0];
    @(negedge clk);
  endtask

  function automatic int refSum(input int v [8]);
    int s = 0;
    for (int j = 0; j < 8; j++) begin
      logic signed [7:0] b;
      b = v[j][7:0];
      s += int'(b);
    end
    return s;
  endfunction

  function automatic int got();
    return int'($signed(total));
  endfunction

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish();
  end

  initial begin
    int v [8];
    int r [8];
    int base;
    for (int j = 0; j < 8; j++) op[j] = 8'h00;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 reset state", got(), 0);

    // table of vectors
    for (int k = 0; k < 9; k++) begin
      for (int j = 0; j < 8; j++) v[j] = TV[k][j];
      apply(v);
      check(tag[k], got(), TV[k][8]);
    end

    // all-ones pattern for a lone -1 (R8)
    for (int j = 0; j < 8; j++) v[j] = 0;
    v[5] = -1;
    apply(v);
    check("R8 raw bits", int'(total), 32'h7FF);

    // random operand sets against a behavioural sum (R1)
    for (int n = 0; n < 300; n++) begin
      for (int j = 0; j < 8; j++) v[j] = int'($urandom_range(0, 255)) - 128;
      apply(v);
      check("R1 random", got(), refSum(v));
    end

    // operand rotation gives the same total (R7)
    for (int n = 0; n < 16; n++) begin
      for (int j = 0; j < 8; j++) v[j] = int'($urandom_range(0, 255)) - 128;
      apply(v);
      base = got();
      for (int rot = 1; rot < 8; rot++) begin
        for (int j = 0; j < 8; j++) r[j] = v[(j + rot) % 8];
        apply(r);
        check("R7 rotation", got(), base);
      end
    end

    // one group at an extreme, the other random (R5)
    for (int n = 0; n < 20; n++) begin
      for (int j = 0; j < 8; j++) v[j] = int'($urandom_range(0, 255)) - 128;
      for (int j = 0; j < 4; j++) v[(n % 2) * 4 + j] = (n % 4 < 2) ? -128 : 127;
      apply(v);
      check("R5 group extreme", got(), refSum(v));
    end

    finish();
  end
endmodule